// File: doc/BRIEF.md
# Latency-Modelling Memory Responder

This block stands in for a slow external memory at the far end of a block-wide request channel. A requester offers one request per cycle on a valid/ready handshake. The request carries a block address, a write flag, a byte-enable mask, one block of data and a tag. A write changes the internal block store at once under its byte mask and is never answered. A read copies the addressed block and its tag into a small table of pending responses. Each table entry then counts down a fixed number of cycles before it may be returned.

Answers leave on a second valid/ready channel. The responder raises response-valid only while the requester holds response-ready. Among the entries whose count has run out, the one in the lowest table slot goes first. Slots are reused, so a young entry in a low slot can overtake an older entry in a higher one. Request-ready can also be pulled low in two ways: by a periodic stall that models a busy memory, and by a cap on how many reads may be outstanding.

Top module: `lat_mem_responder`

## Requirements
- R1: After reset the pending table is empty, and response-valid stays low even while response-ready is high.
- R2: An accepted write replaces exactly the bytes of the addressed block whose enable bit is set (bit b covers data bits 8b+7 down to 8b). It never produces a response.
- R3: A read accepted at the clock edge that ends cycle n is first offered in cycle n+1+LATENCY, and not before. It carries the tag of the request and the block contents as of the acceptance edge.
- R4: Response-valid is high only in cycles where response-ready is high. An expired entry waits, unchanged, for as long as response-ready stays low.
- R5: When several entries have expired, the one in the lowest table slot is returned first. A new read takes the lowest free slot.
- R6: With stall injection enabled, request-ready is low in every cycle whose index since reset release (the first cycle being index 0) is a multiple of STALL_MOD.
- R7: Request-ready is low whenever QUEUE_LIMIT reads are pending. It returns once a response frees an entry, outside stall cycles.
- R8: A request can be accepted and a response returned in the same cycle. A returned entry is freed at that edge and can be reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Block address |
| req_be | input | BLK_BYTES | Byte enables for a write |
| req_data | input | 8*BLK_BYTES | Write data |
| req_tag | input | TAG_W | Tag echoed on the read response |
| rsp_valid | output | 1 | Read response presented |
| rsp_ready | input | 1 | Requester can take a response |
| rsp_data | output | 8*BLK_BYTES | Read block |
| rsp_tag | output | TAG_W | Tag of the read |

## Verification
The assertions assume that the requester never reads a block it has not written, since the store is not cleared by reset. They also assume that a request held high while ready is low may change freely, because the handshake is only sampled in ready cycles. The bench writes every block before reading it. It changes requests and response-ready only just after the falling clock edge, so each handshake is decided by a single sampled cycle. The latency and ordering checks are timed from the cycle of acceptance the bench observes, so stall cycles that delay acceptance do not skew the expected values.

// File: rtl/mresp_pkg.sv
package mresp_pkg;

  // index of the lowest set bit, or -1 when none is set
  function automatic int lowest_set(input logic [31:0] vec);
    for (int i = 0; i < 32; i++) begin
      if (vec[i]) return i;
    end
    return -1;
  endfunction

  // stall rule: cycle counts that are a multiple of the modulo are blocked
  function automatic logic stall_hit(input int unsigned phase);
    return (phase == 0);
  endfunction

endpackage

// File: rtl/mresp_stall_gen.sv
module mresp_stall_gen #(
  parameter int STALL_EN  = 1,
  parameter int STALL_MOD = 8
) (
  input  logic clk,
  input  logic rst,
  output logic stall_o
);
  localparam int CW = $clog2(STALL_MOD + 1);

  generate
    if (STALL_EN != 0) begin : g_stall
      logic [CW-1:0] phase_q;
      always_ff @(posedge clk) begin
        if (rst)                                phase_q <= '0;
        else if (phase_q == CW'(STALL_MOD - 1)) phase_q <= '0;
        else                                    phase_q <= phase_q + 1'b1;
      end
      assign stall_o = mresp_pkg::stall_hit(int'(phase_q));
    end else begin : g_nostall
      assign stall_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mresp_block_ram.sv
module mresp_block_ram #(
  parameter int BLK_BYTES = 8,
  parameter int ADDR_W    = 6
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [BLK_BYTES-1:0]   wr_be,
  input  logic [BLK_BYTES*8-1:0] wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [BLK_BYTES*8-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BLK_BYTES*8-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BLK_BYTES; b++) begin
        if (wr_be[b]) store[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/mresp_pend_table.sv
module mresp_pend_table #(
  parameter int SLOTS   = 4,
  parameter int LATENCY = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         alloc_i,
  input  logic [TAG_W-1:0]             alloc_tag,
  input  logic [DATA_W-1:0]            alloc_data,
  input  logic                         rsp_ready_i,
  output logic                         rsp_valid_o,
  output logic [TAG_W-1:0]             rsp_tag_o,
  output logic [DATA_W-1:0]            rsp_data_o,
  output logic                         free_o,
  output logic [$clog2(SLOTS+1)-1:0]   occ_o
);
  localparam int CW    = $clog2(LATENCY + 1);
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int OCC_W = $clog2(SLOTS + 1);

  logic [SLOTS-1:0] vld_q;
  logic [CW-1:0]    cnt_q  [SLOTS];
  logic [TAG_W-1:0] tag_q  [SLOTS];
  logic [DATA_W-1:0] data_q [SLOTS];

  logic [SLOTS-1:0] open_vec, done_vec;
  int               alloc_idx, pick_idx;
  logic [SW-1:0]    pick_sel;
  logic             any_done;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      open_vec[i] = !vld_q[i];
      done_vec[i] = vld_q[i] && (cnt_q[i] == '0);
    end
    alloc_idx = mresp_pkg::lowest_set(32'(open_vec));
    pick_idx  = mresp_pkg::lowest_set(32'(done_vec));
    any_done  = |done_vec;
    pick_sel  = any_done ? SW'(pick_idx) : '0;
  end

  assign rsp_valid_o = any_done && rsp_ready_i;
  assign free_o      = rsp_valid_o;
  assign rsp_tag_o   = tag_q[pick_sel];
  assign rsp_data_o  = data_q[pick_sel];

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      logic take_here, drop_here;
      assign take_here = alloc_i && (alloc_idx == g);
      assign drop_here = free_o && (pick_idx == g);

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q[g] <= 1'b0;
          cnt_q[g] <= '0;
        end else if (take_here) begin
          vld_q[g] <= 1'b1;
          cnt_q[g] <= CW'(LATENCY);
        end else if (drop_here) begin
          vld_q[g] <= 1'b0;
        end else if (vld_q[g] && cnt_q[g] != '0) begin
          cnt_q[g] <= cnt_q[g] - 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (take_here) begin
          tag_q[g]  <= alloc_tag;
          data_q[g] <= alloc_data;
        end
      end
    end
  endgenerate

  always_comb begin
    occ_o = '0;
    for (int i = 0; i < SLOTS; i++) occ_o = occ_o + OCC_W'(vld_q[i]);
  end
endmodule

// File: rtl/lat_mem_responder.sv
module lat_mem_responder #(
  parameter int BLK_BYTES   = 8,
  parameter int ADDR_W      = 6,
  parameter int TAG_W       = 4,
  parameter int LATENCY     = 4,
  parameter int SLOTS       = 4,
  parameter int QUEUE_LIMIT = 4,
  parameter int STALL_EN    = 1,
  parameter int STALL_MOD   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_wr,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [BLK_BYTES-1:0]   req_be,
  input  logic [BLK_BYTES*8-1:0] req_data,
  input  logic [TAG_W-1:0]       req_tag,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [BLK_BYTES*8-1:0] rsp_data,
  output logic [TAG_W-1:0]       rsp_tag
);
  localparam int DATA_W = BLK_BYTES * 8;
  localparam int OCC_W  = $clog2(SLOTS + 1);

  // named internal events, observed by the bound checker
  logic             stall_now;
  logic             table_full;
  logic             req_fire, wr_fire, alloc_fire, free_fire;
  logic [OCC_W-1:0] occ;
  logic [DATA_W-1:0] blk_rd;

  mresp_stall_gen #(.STALL_EN(STALL_EN), .STALL_MOD(STALL_MOD)) u_stall (
    .clk(clk), .rst(rst), .stall_o(stall_now)
  );

  assign table_full = (occ >= OCC_W'(QUEUE_LIMIT));
  assign req_ready  = !stall_now && !table_full;
  assign req_fire   = req_valid && req_ready;
  assign wr_fire    = req_fire && req_wr;
  assign alloc_fire = req_fire && !req_wr;

  mresp_block_ram #(.BLK_BYTES(BLK_BYTES), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .wr_en(wr_fire), .wr_addr(req_addr), .wr_be(req_be),
    .wr_data(req_data), .rd_addr(req_addr), .rd_data(blk_rd)
  );

  mresp_pend_table #(.SLOTS(SLOTS), .LATENCY(LATENCY), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_pend (
    .clk(clk), .rst(rst),
    .alloc_i(alloc_fire), .alloc_tag(req_tag), .alloc_data(blk_rd),
    .rsp_ready_i(rsp_ready), .rsp_valid_o(rsp_valid),
    .rsp_tag_o(rsp_tag), .rsp_data_o(rsp_data),
    .free_o(free_fire), .occ_o(occ)
  );
endmodule

// File: rtl/lat_mem_responder_chk.sv
module lat_mem_responder_chk #(
  parameter int QUEUE_LIMIT = 4,
  parameter int OCC_W       = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_wr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             stall_now,
  input logic             alloc_fire,
  input logic             free_fire,
  input logic [OCC_W-1:0] occ
);
  p_empty_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> !rsp_valid);

  p_write_no_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_wr) |-> !alloc_fire);

  p_rsp_needs_ready_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_ready);

  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    stall_now |-> !req_ready);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(QUEUE_LIMIT));

  p_full_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(QUEUE_LIMIT)) |-> !req_ready);

  p_occ_track_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (occ == $past(occ) + OCC_W'($past(alloc_fire)) - OCC_W'($past(free_fire))));
endmodule

bind lat_mem_responder lat_mem_responder_chk #(.QUEUE_LIMIT(QUEUE_LIMIT), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .stall_now(stall_now),
  .alloc_fire(alloc_fire), .free_fire(free_fire), .occ(occ)
);

// File: tb/lat_mem_responder_bench.sv
module lat_mem_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT   = 4;
  localparam int SMOD  = 8;
  localparam int LIMIT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_wr = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [7:0]  req_be = '0;
  logic [63:0] req_data = '0;
  logic [3:0]  req_tag = '0;
  logic        rsp_ready = 1'b0;
  logic        req_ready, rsp_valid;
  logic [63:0] rsp_data;
  logic [3:0]  rsp_tag;

  int n_chk = 0, n_fail = 0;
  int bcyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) bcyc <= 0;
    else     bcyc <= bcyc + 1;
  end

  lat_mem_responder u_lat_mem_responder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_be(req_be), .req_data(req_data),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_tag(rsp_tag)
  );

  localparam logic [63:0] BLK5 = 64'h1122334455AA77AA;
  localparam logic [63:0] BLK6 = 64'h0F0E0D0C0B0A0908;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [5:0] a, input logic [7:0] be,
                       input logic [63:0] d, input logic [3:0] t, output int acc);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_be = be; req_data = d; req_tag = t;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc = bcyc;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b0; rsp_ready = 1'b1; #1;
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b0, "R6", "ready in cycle 0", 64'(req_ready), 64'd0);
    skip(3); #1;
    check(rsp_valid == 1'b0, "R1", "rsp_valid idle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_stall_pattern();
    for (int i = 0; i < 2*SMOD; i++) begin
      @(negedge clk); #1;
      check(req_ready == ((bcyc % SMOD) != 0), "R6", "stall pattern",
            64'(req_ready), 64'((bcyc % SMOD) != 0));
    end
  endtask

  task automatic t_write_read();
    int acc;
    rsp_ready = 1'b1;
    issue(1'b1, 6'd5, 8'hFF, 64'h1122334455667788, 4'd0, acc);
    issue(1'b1, 6'd5, 8'b0000_0101, 64'hAAAAAAAAAAAAAAAA, 4'd0, acc);
    issue(1'b1, 6'd6, 8'hFF, BLK6, 4'd0, acc);
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk); #1;
      check(rsp_valid == 1'b0, "R2", "write produced no response", 64'(rsp_valid), 64'd0);
    end
    issue(1'b0, 6'd5, 8'h00, 64'd0, 4'd9, acc);
    while (bcyc < acc + LAT) begin @(negedge clk); #1; end
    check(rsp_valid == 1'b0, "R3", "not valid one cycle early", 64'(rsp_valid), 64'd0);
    @(negedge clk); #1;
    check(rsp_valid == 1'b1, "R3", "valid at latency", 64'(rsp_valid), 64'd1);
    check(rsp_tag == 4'd9, "R3", "tag", 64'(rsp_tag), 64'd9);
    check(rsp_data == BLK5, "R2", "masked merge", rsp_data, BLK5);
    @(negedge clk); #1;
    check(rsp_valid == 1'b0, "R8", "entry freed after return", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_hold();
    int acc;
    rsp_ready = 1'b0;
    issue(1'b0, 6'd6, 8'h00, 64'd0, 4'd4, acc);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #1;
      check(rsp_valid == 1'b0, "R4", "no valid without ready", 64'(rsp_valid), 64'd0);
    end
    @(negedge clk); rsp_ready = 1'b1; #1;
    check(rsp_valid == 1'b1 && rsp_tag == 4'd4, "R4", "held entry tag", 64'(rsp_tag), 64'd4);
    check(rsp_data == BLK6, "R4", "held entry data", rsp_data, BLK6);
    @(negedge clk); #1;
    check(rsp_valid == 1'b0, "R4", "taken once", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_order();
    int acc;
    rsp_ready = 1'b0;
    issue(1'b0, 6'd5, 8'h00, 64'd0, 4'd1, acc);
    issue(1'b0, 6'd6, 8'h00, 64'd0, 4'd2, acc);
    skip(LAT + 2);
    @(negedge clk); rsp_ready = 1'b1; #1;
    check(rsp_valid && rsp_tag == 4'd1, "R5", "slot 0 first", 64'(rsp_tag), 64'd1);
    @(negedge clk); rsp_ready = 1'b0;
    issue(1'b0, 6'd5, 8'h00, 64'd0, 4'd3, acc);
    skip(LAT + 2);
    @(negedge clk); rsp_ready = 1'b1; #1;
    check(rsp_valid && rsp_tag == 4'd3, "R5", "younger entry in low slot first", 64'(rsp_tag), 64'd3);
    check(rsp_data == BLK5, "R5", "data of slot 0", rsp_data, BLK5);
    @(negedge clk); #1;
    check(rsp_valid && rsp_tag == 4'd2, "R5", "older entry second", 64'(rsp_tag), 64'd2);
    check(rsp_data == BLK6, "R5", "data of slot 1", rsp_data, BLK6);
    @(negedge clk); #1;
    check(rsp_valid == 1'b0, "R5", "table drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_backpressure();
    int acc;
    rsp_ready = 1'b0;
    for (int k = 0; k < LIMIT; k++) issue(1'b0, 6'd5, 8'h00, 64'd0, 4'(10 + k), acc);
    for (int i = 0; i < 2*SMOD; i++) begin
      @(negedge clk); #1;
      check(req_ready == 1'b0, "R7", "ready low when full", 64'(req_ready), 64'd0);
    end
    @(negedge clk); rsp_ready = 1'b1; #1;
    check(rsp_valid && rsp_tag == 4'd10, "R7", "first drained tag", 64'(rsp_tag), 64'd10);
    @(negedge clk); rsp_ready = 1'b0; #1;
    while ((bcyc % SMOD) == 0) begin @(negedge clk); #1; end
    check(req_ready == 1'b1, "R7", "ready back after free", 64'(req_ready), 64'd1);
    @(negedge clk); rsp_ready = 1'b1;
    for (int k = 1; k < LIMIT; k++) begin
      #1;
      check(rsp_valid && rsp_tag == 4'(10 + k), "R7", "remaining tags in slot order",
            64'(rsp_tag), 64'(10 + k));
      @(negedge clk);
    end
  endtask

  task automatic t_stream();
    bit both = 1'b0;
    rsp_ready = 1'b1;
    fork
      begin
        int acc;
        for (int k = 0; k < 10; k++) issue(1'b0, 6'd6, 8'h00, 64'd0, 4'(k), acc);
      end
      begin
        int got = 0;
        while (got < 10) begin
          @(negedge clk); #1;
          if (rsp_valid) begin
            check(rsp_tag == 4'(got) && rsp_data == BLK6, "R8", "streamed response",
                  64'(rsp_tag), 64'(got));
            if (req_valid && req_ready) both = 1'b1;
            got++;
          end
        end
      end
    join
    check(both, "R8", "accept and return in one cycle", 64'(both), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL all watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    skip(4);
    t_reset();
    t_stall_pattern();
    t_write_read();
    t_hold();
    t_order();
    t_backpressure();
    t_stream();
    skip(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule